// File: doc/BRIEF.md
# Option-Configured Cycle Clock and Reset Controller

This block sits between a raw oscillator clock and the rest of a small controller core. It derives the one-clock instruction-cycle strobe from the oscillator in two stages. A predivider first divides the clock by 1, 3 or 4, selected by a two-bit option code. A fixed stage then counts four predivided ticks per instruction cycle. The block also turns an asynchronous reset pin into a clean internal reset. A pulse on the pin must stay low for a minimum number of clocks before it counts, and the internal reset is released only at an instruction-cycle boundary.

The configuration comes from option bits that non-volatile storage holds steady at power-up. The block captures these bits only while the internal reset is active. From the captured bits it sets the power-up levels of two 4-bit output ports, one level per port. It also decides whether a shared pin is an ordinary port bit or a watchdog input. In watchdog mode, a long enough low level on that pin resets the core the same way the reset pin does. The reserved predivider code falls back to divide-by-1 and raises an error flag.

Top module: `optclk_rst_ctrl`

## Requirements
- R1: The strobe period is 4 × ratio oscillator clocks, with the captured predivider code mapping 2'b00 to ratio 1 (period 4), 2'b01 to ratio 3 (period 12) and 2'b10 to ratio 4 (period 16).
- R2: `cyc_stb` is high for exactly one oscillator clock per instruction cycle.
- R3: A captured predivider code of 2'b11 gives the divide-by-1 period of 4 clocks and holds `cfg_err` high; for any other code `cfg_err` is low.
- R4: `sys_rst` rises only after the reset pin has been seen low for 4 consecutive clocks after its two-flop synchronizer. A low pulse of 3 clocks or fewer leaves `sys_rst` low.
- R5: Once every reset source is high again, `sys_rst` falls on the clock edge at which `cyc_stb` is high, so the first cycle out of reset starts on an instruction-cycle boundary.
- R6: `port_c_init` is 4'hF when the captured port-C option bit is 1 and 4'h0 when it is 0. `port_d_init` follows the port-D option bit the same way.
- R7: The option inputs are captured only while `sys_rst` is high. Changing them while `sys_rst` is low has no effect on `port_c_init`, `port_d_init`, `e1_is_wdt`, `cfg_err` or the strobe period.
- R8: With the captured watchdog option at 1, `e1_is_wdt` is 1, and a low on `wdt_pin_n` held for 4 synchronized clocks raises `sys_rst`. With the option at 0, `e1_is_wdt` is 0 and `wdt_pin_n` has no effect on `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Raw oscillator clock |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| wdt_pin_n | input | 1 | Shared pin used as the watchdog reset input when enabled, active low |
| opt_prediv | input | 2 | Predivider option code |
| opt_pc_hi | input | 1 | Port C reset level option (1 = high) |
| opt_pd_hi | input | 1 | Port D reset level option (1 = high) |
| opt_wdt_en | input | 1 | Watchdog function option for the shared pin |
| cyc_stb | output | 1 | One-clock instruction-cycle strobe |
| sys_rst | output | 1 | Synchronous internal reset, active high |
| port_c_init | output | 4 | Reset output value for port C |
| port_d_init | output | 4 | Reset output value for port D |
| e1_is_wdt | output | 1 | Shared pin acts as the watchdog input |
| cfg_err | output | 1 | Reserved predivider code was captured |

## Verification
Two events can fall on the same clock edge: the release of the internal reset and the last capture of the option bits. Option capture stays open until the strobe edge that releases the reset. To provoke the overlap, the bench drives new option values on the very first clock after the reset falls. It then judges the result at the ports: the port levels, the pin-function select, the error flag and the measured strobe period must all still show the values captured before the release. Minimum-width filtering is probed with 3- and 4-clock pulses on both reset sources. Each of the four predivider codes is measured as a strobe period.

// File: rtl/optclk_pkg.sv
`timescale 1ns/1ps
package optclk_pkg;
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned RATIO_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PDIV_1   = 2'b00,
    PDIV_3   = 2'b01,
    PDIV_4   = 2'b10,
    PDIV_BAD = 2'b11
  } prediv_e;

  typedef struct packed {
    logic [CODE_W-1:0] prediv;
    logic              pc_hi;
    logic              pd_hi;
    logic              wdt_en;
  } opt_t;

  function automatic logic [RATIO_W-1:0] prediv_ratio(input logic [CODE_W-1:0] code);
    case (code)
      PDIV_3:  return RATIO_W'(3);
      PDIV_4:  return RATIO_W'(4);
      default: return RATIO_W'(1);
    endcase
  endfunction

  function automatic logic code_reserved(input logic [CODE_W-1:0] code);
    return code == PDIV_BAD;
  endfunction
endpackage

// File: rtl/optclk_sync.sv
`timescale 1ns/1ps
module optclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain <= d;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/optclk_rst_filter.sv
`timescale 1ns/1ps
module optclk_rst_filter #(
  parameter int unsigned MIN_LOW = 4
) (
  input  logic clk,
  input  logic low_req,
  input  logic stb,
  output logic trip,
  output logic rst_q
);
  localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);

  logic [CNT_W-1:0] run_cnt;

  // consecutive low samples, saturating at LAST
  always_ff @(posedge clk) begin
    if (!low_req)           run_cnt <= '0;
    else if (run_cnt != LAST) run_cnt <= run_cnt + CNT_W'(1);
  end

  assign trip = low_req && (run_cnt == LAST);

  // set on a long enough low; clear only on a cycle boundary with sources idle
  always_ff @(posedge clk) begin
    if (trip)                  rst_q <= 1'b1;
    else if (!low_req && stb)  rst_q <= 1'b0;
  end
endmodule

// File: rtl/optclk_cycle_div.sv
`timescale 1ns/1ps
module optclk_cycle_div
  import optclk_pkg::*;
#(
  parameter int unsigned CYC_LEN = 4
) (
  input  logic               clk,
  input  logic               clr,
  input  logic [RATIO_W-1:0] ratio,
  output logic               pre_tick,
  output logic               cyc_stb
);
  localparam int unsigned CYC_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_LEN - 1);

  logic [RATIO_W-1:0] pre_cnt;
  logic [CYC_W-1:0]   cyc_cnt;

  // >= guards against a ratio that shrank while the counter was running
  assign pre_tick = (pre_cnt >= (ratio - RATIO_W'(1)));
  assign cyc_stb  = pre_tick && (cyc_cnt == CYC_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      pre_cnt <= '0;
      cyc_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + RATIO_W'(1);
      if (pre_tick) cyc_cnt <= (cyc_cnt == CYC_LAST) ? '0 : cyc_cnt + CYC_W'(1);
    end
  end
endmodule

// File: rtl/optclk_rst_ctrl.sv
`timescale 1ns/1ps
module optclk_rst_ctrl
  import optclk_pkg::*;
#(
  parameter int unsigned MIN_LOW     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CYC_LEN     = 4,
  parameter int unsigned PORT_W      = 4
) (
  input  logic              osc_clk,
  input  logic              rst_pin_n,
  input  logic              wdt_pin_n,
  input  logic [CODE_W-1:0] opt_prediv,
  input  logic              opt_pc_hi,
  input  logic              opt_pd_hi,
  input  logic              opt_wdt_en,
  output logic              cyc_stb,
  output logic              sys_rst,
  output logic [PORT_W-1:0] port_c_init,
  output logic [PORT_W-1:0] port_d_init,
  output logic              e1_is_wdt,
  output logic              cfg_err
);
  opt_t opt_q;
  logic rst_s, wdt_s, low_req, trip, hold, pre_tick;

  // option capture window is the internal reset
  always_ff @(posedge osc_clk) begin
    if (sys_rst) opt_q <= '{prediv: opt_prediv, pc_hi: opt_pc_hi,
                            pd_hi: opt_pd_hi, wdt_en: opt_wdt_en};
  end

  optclk_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(osc_clk), .d(rst_pin_n), .q(rst_s));
  optclk_sync #(.STAGES(SYNC_STAGES)) u_wdt_sync (
    .clk(osc_clk), .d(wdt_pin_n), .q(wdt_s));

  assign low_req = !rst_s || (opt_q.wdt_en && !wdt_s);

  optclk_rst_filter #(.MIN_LOW(MIN_LOW)) u_filter (
    .clk(osc_clk), .low_req(low_req), .stb(cyc_stb),
    .trip(trip), .rst_q(sys_rst));

  assign hold = sys_rst && low_req;

  optclk_cycle_div #(.CYC_LEN(CYC_LEN)) u_div (
    .clk(osc_clk), .clr(hold), .ratio(prediv_ratio(opt_q.prediv)),
    .pre_tick(pre_tick), .cyc_stb(cyc_stb));

  assign port_c_init = {PORT_W{opt_q.pc_hi}};
  assign port_d_init = {PORT_W{opt_q.pd_hi}};
  assign e1_is_wdt   = opt_q.wdt_en;
  assign cfg_err     = code_reserved(opt_q.prediv);

  // R2: the strobe never lasts two clocks
  a_r2_stb_single: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
    cyc_stb |=> !cyc_stb);

  // R3: reserved code runs the predivider at full rate
  a_r3_err_full_rate: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
    cfg_err |-> pre_tick);

  // R5: release lands on a cycle boundary
  a_r5_release_on_stb: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
    $fell(sys_rst) |-> $past(cyc_stb));

  // R7: captured options frozen outside reset
  a_r7_opts_frozen: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
    (!sys_rst && !$past(sys_rst)) |->
      ($stable(port_c_init) && $stable(port_d_init) && $stable(e1_is_wdt) && $stable(cfg_err)));

  // R4 / R8: a new reset needs four prior low requests
  generate
    if (MIN_LOW == 4) begin : g_min4
      a_r4_min_low: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
        $rose(sys_rst) |-> ($past(low_req, 1) && $past(low_req, 2) &&
                            $past(low_req, 3) && $past(low_req, 4)));
    end
  endgenerate
endmodule

// File: tb/optclk_rst_ctrl_bench.sv
`timescale 1ns/1ps
module optclk_rst_ctrl_bench;
  logic       osc_clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       wdt_pin_n = 1'b1;
  logic [1:0] opt_prediv = 2'b00;
  logic       opt_pc_hi = 1'b0, opt_pd_hi = 1'b0, opt_wdt_en = 1'b0;
  logic       cyc_stb, sys_rst, e1_is_wdt, cfg_err;
  logic [3:0] port_c_init, port_d_init;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 osc_clk = ~osc_clk;

  optclk_rst_ctrl u_optclk_rst_ctrl (
    .osc_clk(osc_clk), .rst_pin_n(rst_pin_n), .wdt_pin_n(wdt_pin_n),
    .opt_prediv(opt_prediv), .opt_pc_hi(opt_pc_hi), .opt_pd_hi(opt_pd_hi),
    .opt_wdt_en(opt_wdt_en), .cyc_stb(cyc_stb), .sys_rst(sys_rst),
    .port_c_init(port_c_init), .port_d_init(port_d_init),
    .e1_is_wdt(e1_is_wdt), .cfg_err(cfg_err));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  function automatic int exp_period(input logic [1:0] code);
    int r;
    r = (code == 2'b01) ? 3 : (code == 2'b10) ? 4 : 1;
    return 4 * r;
  endfunction

  // pins high again; wait for fall and confirm it follows a strobe (R5)
  task automatic wait_release();
    logic prev_stb = 1'b0;
    int   seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      prev_stb = cyc_stb;
      @(negedge osc_clk);
      if (!sys_rst) begin
        seen = 1;
        check("R5 strobe before release", prev_stb, 1);
      end
    end
    check("R5 reset released", seen, 1);
  endtask

  task automatic apply_reset(input logic [1:0] code, input logic pc, input logic pd, input logic wd);
    opt_prediv = code; opt_pc_hi = pc; opt_pd_hi = pd; opt_wdt_en = wd;
    rst_pin_n = 1'b0;
    tick(10);
    check("R4 reset held", sys_rst, 1);
    rst_pin_n = 1'b1;
    wait_release();
  endtask

  task automatic measure_period(output int per);
    int k = 0;
    per = -1;
    while (!cyc_stb && k < 60) begin tick(1); k++; end
    tick(1);
    for (int i = 1; i < 60; i++) begin
      if (cyc_stb && per < 0) per = i;
      if (per < 0) tick(1);
    end
  endtask

  // R1, R2, R3: period per code, pulse width, error flag
  task automatic t_codes();
    int per;
    for (int c = 0; c < 4; c++) begin
      apply_reset(2'(c), 1'b1, 1'b0, 1'b0);
      measure_period(per);
      check(c == 3 ? "R3 reserved period" : "R1 period", per, exp_period(2'(c)));
      tick(1);
      check("R2 strobe one clock", cyc_stb, 0);
      check("R3 cfg_err", cfg_err, c == 3 ? 1 : 0);
    end
  endtask

  // R6: port init levels from both option settings
  task automatic t_ports();
    apply_reset(2'b00, 1'b1, 1'b0, 1'b0);
    check("R6 port C high", port_c_init, 15);
    check("R6 port D low", port_d_init, 0);
    apply_reset(2'b00, 1'b0, 1'b1, 1'b0);
    check("R6 port C low", port_c_init, 0);
    check("R6 port D high", port_d_init, 15);
  endtask

  // R4: pulse length filter on the reset pin
  task automatic t_pulse_width();
    int hit;
    apply_reset(2'b00, 1'b0, 1'b0, 1'b0);
    rst_pin_n = 1'b0; tick(3); rst_pin_n = 1'b1;
    hit = 0;
    for (int i = 0; i < 10; i++) begin tick(1); if (sys_rst) hit = 1; end
    check("R4 3-clock pulse ignored", hit, 0);
    rst_pin_n = 1'b0; tick(4); rst_pin_n = 1'b1;
    hit = 0;
    for (int i = 0; i < 6; i++) begin tick(1); if (sys_rst) hit = 1; end
    check("R4 4-clock pulse resets", hit, 1);
    wait_release();
  endtask

  // R7: option change right after release has no effect
  task automatic t_frozen();
    int per;
    apply_reset(2'b01, 1'b1, 1'b0, 1'b0);
    opt_prediv = 2'b11; opt_pc_hi = 1'b0; opt_pd_hi = 1'b1; opt_wdt_en = 1'b1;
    tick(20);
    check("R7 port C kept", port_c_init, 15);
    check("R7 port D kept", port_d_init, 0);
    check("R7 wdt select kept", e1_is_wdt, 0);
    check("R7 cfg_err kept", cfg_err, 0);
    measure_period(per);
    check("R7 period kept", per, 12);
  endtask

  // R8: watchdog pin enabled / disabled
  task automatic t_watchdog();
    int hit;
    apply_reset(2'b00, 1'b0, 1'b0, 1'b1);
    check("R8 pin is watchdog", e1_is_wdt, 1);
    wdt_pin_n = 1'b0; tick(3); wdt_pin_n = 1'b1;
    hit = 0;
    for (int i = 0; i < 10; i++) begin tick(1); if (sys_rst) hit = 1; end
    check("R8 short watchdog low ignored", hit, 0);
    wdt_pin_n = 1'b0; tick(4); wdt_pin_n = 1'b1;
    hit = 0;
    for (int i = 0; i < 6; i++) begin tick(1); if (sys_rst) hit = 1; end
    check("R8 watchdog resets", hit, 1);
    wait_release();
    apply_reset(2'b00, 1'b0, 1'b0, 1'b0);
    check("R8 pin is port bit", e1_is_wdt, 0);
    wdt_pin_n = 1'b0;
    hit = 0;
    for (int i = 0; i < 12; i++) begin tick(1); if (sys_rst) hit = 1; end
    wdt_pin_n = 1'b1;
    check("R8 disabled watchdog ignored", hit, 0);
  endtask

  initial begin
    tick(8);
    check("R4 reset state", sys_rst, 1);
    rst_pin_n = 1'b1;
    wait_release();
    t_codes();
    t_ports();
    t_pulse_width();
    t_frozen();
    t_watchdog();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule